// File: doc/BRIEF.md
# Rate-Adaptive Parity Puncturing Serializer

This block sits after the two constituent encoders of a duobinary turbo encoder. For each couple index k of a frame it takes in the systematic couple and the Y and W parity couples from both encoders. The whole frame is held in a local buffer. The block then plays the frame out as one continuous stream of two-bit couples, one couple per cycle. Each stream carries one QPSK symbol.

The code rate setting decides which parity survives. At the lowest rate every parity couple is sent. At the next rate, W is thinned to the even indices. From rate 1/2 upwards, W is dropped entirely, and Y is thinned to every M-th index. An order setting chooses between two layouts. The first sends data, then Y, then W. The second sends Y, then W, then data. Deleted indices are skipped, not idled over, so the output is valid on every cycle from the first couple to the last.

The W buffer is written only when the selected rate transmits W. At the higher rates that storage keeps its old contents and does not toggle.

Top module: `pps_punct_serializer`

## Requirements
- R1: After reset, out_valid and out_last are low and in_ready is high.
- R2: While in_ready is high, each cycle with in_valid high stores one couple index, in order from k=0. cfg_rate, cfg_order and cfg_len are captured with index 0. Once cfg_len indices are stored, emission starts on the next cycle. During emission in_ready is low, and in_valid, data and cfg inputs have no effect on the output.
- R3: With cfg_order=0 the output sends all kept data couples, then all kept Y couples, then all kept W couples, each section in increasing k.
- R4: With cfg_order=1 the output sends the kept Y couples, then the kept W couples, then the data couples, each section in increasing k.
- R5: Rate code cfg_rate=0 (1/3) keeps every W. Code 1 (2/5) keeps W only at even k. Both codes keep every Y.
- R6: Rate codes 2 to 6 (1/2, 2/3, 3/4, 4/5, 6/7) send no W couple at all.
- R7: For codes 2, 3, 4, 5 and 6, Y is kept at k with k mod M = 0, where M is 1, 2, 3, 4 and 6 respectively. This holds for any frame length, including lengths that M does not divide.
- R8: out_valid stays high on every cycle from the first emitted couple to the last. The couple count equals the number of kept couples.
- R9: out_last is high on exactly the final emitted couple. On the next cycle out_valid is low and in_ready is high.
- R10: For rate codes 2 to 6 the W buffer is not written while a frame is loaded.
- R11: In out_couple, bit 1 carries the first member of a couple (A, Y1 or W1) and bit 0 the second (B, Y2 or W2). The in_sys, in_y and in_w inputs use the same packing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rate | input | 3 | Code rate code 0..6, sampled with index 0 |
| cfg_order | input | 1 | 0: data first, 1: parity first; sampled with index 0 |
| cfg_len | input | $clog2(MAX_N+1) | Frame length N in couples, 1..MAX_N, sampled with index 0 |
| in_valid | input | 1 | Input couple set present |
| in_ready | output | 1 | High while loading, low during emission |
| in_sys | input | 2 | Systematic couple {A, B} |
| in_y | input | 2 | Y parity couple {Y1, Y2} |
| in_w | input | 2 | W parity couple {W1, W2} |
| out_valid | output | 1 | Output couple present |
| out_couple | output | 2 | Output couple |
| out_last | output | 1 | Final couple of the frame |

## Verification
The bench builds the block with MAX_N=64, so frames can run from a single couple up to the full buffer depth. It uses lengths 12 and 13, one divisible by 2, 3, 4 and 6 and one divisible by none of them. This exposes the rates that end on a partial stride and the final kept Y index for each stride. A single-couple frame and a full 64-couple frame cover the address and length edges. Frames run back to back with junk inputs driven during emission, which shows that captured settings and stored data stay fixed until the frame ends.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [2:0] {
        RATE_1_3 = 3'd0,
        RATE_2_5 = 3'd1,
        RATE_1_2 = 3'd2,
        RATE_2_3 = 3'd3,
        RATE_3_4 = 3'd4,
        RATE_4_5 = 3'd5,
        RATE_6_7 = 3'd6
    } rate_e;

    typedef enum logic [1:0] {
        SEC_SYS  = 2'd0,
        SEC_YPAR = 2'd1,
        SEC_WPAR = 2'd2
    } sect_e;

    // One stored couple index: bit 1 of each field is the first member
    typedef struct packed {
        logic [1:0] sys;
        logic [1:0] ypar;
        logic [1:0] wpar;
    } slot_t;

    // W survives only at the two lowest rates
    function automatic logic w_active(rate_e r);
        return (r == RATE_1_3) || (r == RATE_2_5);
    endfunction

    function automatic logic [2:0] y_stride(rate_e r);
        case (r)
            RATE_2_3: return 3'd2;
            RATE_3_4: return 3'd3;
            RATE_4_5: return 3'd4;
            RATE_6_7: return 3'd6;
            default:  return 3'd1;
        endcase
    endfunction

    function automatic logic [2:0] w_stride(rate_e r);
        return (r == RATE_2_5) ? 3'd2 : 3'd1;
    endfunction

    function automatic sect_e first_sect(logic par_first);
        return par_first ? SEC_YPAR : SEC_SYS;
    endfunction

    function automatic sect_e final_sect(logic par_first, logic w_on);
        if (par_first) return SEC_SYS;
        return w_on ? SEC_WPAR : SEC_YPAR;
    endfunction

    // Successor for every section that is not the final one
    function automatic sect_e next_sect(sect_e cur, logic w_on);
        case (cur)
            SEC_SYS:  return SEC_YPAR;
            SEC_YPAR: return w_on ? SEC_WPAR : SEC_SYS;
            default:  return SEC_SYS;
        endcase
    endfunction

endpackage

// File: rtl/pps_frame_store.sv
module pps_frame_store
    import pps_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_w_en,
    input  logic [AW-1:0] wr_addr,
    input  slot_t         wr_slot,
    input  logic [AW-1:0] rd_addr,
    output slot_t         rd_slot
);

    logic [1:0] sys_mem [DEPTH];
    logic [1:0] y_mem   [DEPTH];
    logic [1:0] w_mem   [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            sys_mem[wr_addr] <= wr_slot.sys;
            y_mem[wr_addr]   <= wr_slot.ypar;
        end
    end

    // Separate enable: W storage stays still when the rate discards W
    always_ff @(posedge clk) begin
        if (wr_en && wr_w_en) begin
            w_mem[wr_addr] <= wr_slot.wpar;
        end
    end

    always_comb begin
        rd_slot.sys  = sys_mem[rd_addr];
        rd_slot.ypar = y_mem[rd_addr];
        rd_slot.wpar = w_mem[rd_addr];
    end

endmodule

// File: rtl/pps_sequencer.sv
module pps_sequencer
    import pps_pkg::*;
#(
    parameter int LW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  rate_e         rate,
    input  logic          par_first,
    input  logic [LW-1:0] len,
    output logic          busy,
    output sect_e         sect,
    output logic [LW-1:0] idx,
    output logic          last
);

    logic          w_on;
    logic [2:0]    stride;
    logic [LW+2:0] nxt;
    logic          end_sect;
    logic          is_final;

    always_comb begin
        w_on = w_active(rate);
        case (sect)
            SEC_YPAR: stride = y_stride(rate);
            SEC_WPAR: stride = w_stride(rate);
            default:  stride = 3'd1;
        endcase
        nxt      = {3'b000, idx} + (LW+3)'(stride);
        end_sect = nxt >= {3'b000, len};
        is_final = sect == final_sect(par_first, w_on);
        last     = busy && end_sect && is_final;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sect <= SEC_SYS;
            idx  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            sect <= first_sect(par_first);
            idx  <= '0;
        end else if (busy) begin
            if (end_sect) begin
                idx <= '0;
                if (is_final) begin
                    busy <= 1'b0;
                end else begin
                    sect <= next_sect(sect, w_on);
                end
            end else begin
                idx <= nxt[LW-1:0];
            end
        end
    end

endmodule

// File: rtl/pps_punct_serializer.sv
module pps_punct_serializer
    import pps_pkg::*;
#(
    parameter int MAX_N = 64,
    localparam int LW = $clog2(MAX_N + 1),
    localparam int AW = $clog2(MAX_N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    cfg_rate,
    input  logic          cfg_order,
    input  logic [LW-1:0] cfg_len,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [1:0]    in_sys,
    input  logic [1:0]    in_y,
    input  logic [1:0]    in_w,
    output logic          out_valid,
    output logic [1:0]    out_couple,
    output logic          out_last
);

    logic [LW-1:0] load_cnt;
    rate_e         rate_q;
    logic          order_q;
    logic [LW-1:0] len_q;

    logic          busy;
    sect_e         sect;
    logic [LW-1:0] idx;
    logic          last;

    logic          accept;
    logic          use_live;
    rate_e         rate_eff;
    logic          order_eff;
    logic [LW-1:0] len_eff;
    logic          frame_done;
    logic          w_store_we;
    slot_t         wr_slot;
    slot_t         rd_slot;

    always_comb begin
        in_ready   = !busy;
        accept     = in_valid && in_ready;
        use_live   = (load_cnt == '0) && !busy;
        rate_eff   = use_live ? rate_e'(cfg_rate) : rate_q;
        order_eff  = use_live ? cfg_order : order_q;
        len_eff    = use_live ? cfg_len : len_q;
        frame_done = accept && (({1'b0, load_cnt} + 1'b1) == {1'b0, len_eff});
        w_store_we = accept && w_active(rate_eff);
        wr_slot    = '{sys: in_sys, ypar: in_y, wpar: in_w};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_cnt <= '0;
            rate_q   <= RATE_1_3;
            order_q  <= 1'b0;
            len_q    <= '0;
        end else if (accept) begin
            if (use_live) begin
                rate_q  <= rate_e'(cfg_rate);
                order_q <= cfg_order;
                len_q   <= cfg_len;
            end
            load_cnt <= frame_done ? '0 : load_cnt + 1'b1;
        end
    end

    pps_frame_store #(.DEPTH(MAX_N)) u_store (
        .clk     (clk),
        .wr_en   (accept),
        .wr_w_en (w_active(rate_eff)),
        .wr_addr (load_cnt[AW-1:0]),
        .wr_slot (wr_slot),
        .rd_addr (idx[AW-1:0]),
        .rd_slot (rd_slot)
    );

    pps_sequencer #(.LW(LW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (frame_done),
        .rate      (rate_eff),
        .par_first (order_eff),
        .len       (len_eff),
        .busy      (busy),
        .sect      (sect),
        .idx       (idx),
        .last      (last)
    );

    always_comb begin
        case (sect)
            SEC_YPAR: out_couple = rd_slot.ypar;
            SEC_WPAR: out_couple = rd_slot.wpar;
            default:  out_couple = rd_slot.sys;
        endcase
        out_valid = busy;
        out_last  = last;
    end

endmodule

// File: rtl/pps_punct_serializer_chk.sv
module pps_punct_serializer_chk #(
    parameter int MAX_N = 64,
    localparam int LW = $clog2(MAX_N + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    cfg_rate,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_last,
    input logic [LW-1:0] load_cnt,
    input logic          w_store_we
);

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_last && in_ready));

    // R2
    a_r2_no_load_while_emitting: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R8
    a_r8_no_gap: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);

    // R9
    a_r9_last_is_valid: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R9
    a_r9_last_closes_frame: assert property (@(posedge clk) disable iff (rst)
        out_last |=> (!out_valid && in_ready));

    // R10
    a_r10_w_store_quiet: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && load_cnt == '0 && cfg_rate >= 3'd2) |-> !w_store_we);

endmodule

bind pps_punct_serializer pps_punct_serializer_chk #(.MAX_N(MAX_N)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_rate   (cfg_rate),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .load_cnt   (load_cnt),
    .w_store_we (w_store_we)
);

// File: tb/tb_pps_punct_serializer.sv
`timescale 1ns/1ps
module tb_pps_punct_serializer;

    localparam int MAX_N = 64;
    localparam int LW = $clog2(MAX_N + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    cfg_rate = '0;
    logic          cfg_order = 1'b0;
    logic [LW-1:0] cfg_len = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [1:0]    in_sys = '0;
    logic [1:0]    in_y = '0;
    logic [1:0]    in_w = '0;
    logic          out_valid;
    logic [1:0]    out_couple;
    logic          out_last;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int unsigned seed = 32'h1234_5678;

    logic [1:0] m_sys [MAX_N];
    logic [1:0] m_y   [MAX_N];
    logic [1:0] m_w   [MAX_N];
    int exp_v [256];
    int exp_n;

    always #2.5 clk = ~clk;

    pps_punct_serializer #(.MAX_N(MAX_N)) dut (
        .clk(clk), .rst(rst), .cfg_rate(cfg_rate), .cfg_order(cfg_order),
        .cfg_len(cfg_len), .in_valid(in_valid), .in_ready(in_ready),
        .in_sys(in_sys), .in_y(in_y), .in_w(in_w), .out_valid(out_valid),
        .out_couple(out_couple), .out_last(out_last)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [1:0] rnd2();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[17:16];
    endfunction

    task automatic check(input bit ok, input string tag, input int got, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, expv);
        end
    endtask

    // Y stride per rate code, from R7
    function automatic int ystep(input int rate);
        case (rate)
            3: return 2;
            4: return 3;
            5: return 4;
            6: return 6;
            default: return 1;
        endcase
    endfunction

    // Expected stream from R3..R7 (0 = data, 1 = Y, 2 = W)
    task automatic build_expected(input int n, input int rate, input int order);
        int secs [3];
        exp_n = 0;
        if (order == 0) begin secs[0] = 0; secs[1] = 1; secs[2] = 2; end
        else            begin secs[0] = 1; secs[1] = 2; secs[2] = 0; end
        for (int s = 0; s < 3; s++) begin
            int step;
            if (secs[s] == 2 && rate >= 2) continue;
            step = (secs[s] == 0) ? 1 : (secs[s] == 1) ? ystep(rate) : ((rate == 1) ? 2 : 1);
            for (int k = 0; k < n; k += step) begin
                exp_v[exp_n] = (secs[s] == 0) ? int'(m_sys[k]) :
                               (secs[s] == 1) ? int'(m_y[k]) : int'(m_w[k]);
                exp_n++;
            end
        end
    endtask

    task automatic load_frame(input int n, input int rate, input int order);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cfg_rate  = 3'(rate);
            cfg_order = order[0];
            cfg_len   = LW'(n);
            in_valid  = 1'b1;
            in_sys    = m_sys[k];
            in_y      = m_y[k];
            in_w      = m_w[k];
        end
    endtask

    task automatic run_frame(input int n, input int rate, input int order,
                             input bit junk, input string tag);
        int got [256];
        int got_n = 0;
        int last_pos = -1;
        int guard = 0;
        int first_bad = -1;
        bit ready_bad = 1'b0;
        for (int k = 0; k < n; k++) begin
            m_sys[k] = rnd2();
            m_y[k]   = rnd2();
            m_w[k]   = rnd2();
        end
        build_expected(n, rate, order);
        load_frame(n, rate, order);
        forever begin
            @(negedge clk);
            in_valid = junk;
            if (junk) begin
                cfg_rate  = 3'(rnd2());
                cfg_order = rnd2() == 2'd1;
                cfg_len   = LW'(rnd2());
                in_sys    = rnd2();
                in_y      = rnd2();
                in_w      = rnd2();
            end
            guard++;
            if (out_valid) begin
                if (in_ready) ready_bad = 1'b1;
                if (got_n < 256) got[got_n] = int'(out_couple);
                if (out_last) last_pos = got_n;
                got_n++;
            end
            if (out_last || guard > 600) break;
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(got_n == exp_n, {tag, " R8 couple count"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            if (first_bad < 0 && got[i] != exp_v[i]) first_bad = i;
        if (first_bad >= 0)
            check(1'b0, {tag, " stream content"}, got[first_bad], exp_v[first_bad]);
        else
            check(1'b1, tag, 0, 0);
        check(last_pos == exp_n - 1 && !out_valid && in_ready,
              {tag, " R9 last position"}, last_pos, exp_n - 1);
        check(!ready_bad, {tag, " R2 in_ready low while emitting"}, int'(ready_bad), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!out_valid && !out_last && in_ready, "R1 reset idle",
              int'({out_valid, out_last, in_ready}), 1);
    endtask

    // R11: fixed single-couple frame, data then Y then W
    task automatic t_pack();
        m_sys[0] = 2'b10; m_y[0] = 2'b01; m_w[0] = 2'b11;
        load_frame(1, 0, 0);
        @(negedge clk); in_valid = 1'b0;
        check(out_valid && out_couple == 2'b10, "R11 A in bit 1", int'(out_couple), 2);
        @(negedge clk);
        check(out_valid && out_couple == 2'b01, "R11 Y2 in bit 0", int'(out_couple), 1);
        @(negedge clk);
        check(out_valid && out_last && out_couple == 2'b11, "R11 W couple last",
              int'(out_couple), 3);
        @(negedge clk);
        check(!out_valid && in_ready, "R9 idle after frame", int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pack();
        run_frame(12, 0, 0, 1'b0, "R3 rate 1/3 data first");
        run_frame(12, 0, 1, 1'b0, "R4 rate 1/3 parity first");
        run_frame(13, 1, 0, 1'b0, "R5 rate 2/5 odd length");
        run_frame(12, 1, 1, 1'b0, "R5 rate 2/5 parity first");
        run_frame(12, 2, 0, 1'b0, "R6 R10 rate 1/2 no W");
        run_frame(13, 3, 0, 1'b0, "R7 rate 2/3 N=13");
        run_frame(13, 4, 1, 1'b0, "R7 rate 3/4 N=13");
        run_frame(12, 5, 0, 1'b0, "R7 rate 4/5 N=12");
        run_frame(13, 6, 0, 1'b0, "R7 rate 6/7 N=13");
        run_frame(1, 6, 1, 1'b0, "R7 rate 6/7 N=1");
        run_frame(MAX_N, 4, 0, 1'b0, "R7 rate 3/4 full depth");
        run_frame(12, 0, 0, 1'b1, "R2 junk during emission");
        run_frame(13, 5, 1, 1'b0, "R2 frame after junk");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule